// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block runs access cycles on an asynchronous parallel memory, such as a NOR flash, that shares one 16-bit bus between address and data. A client raises a request with a direction, a chip-select index, an address and a burst length. The block then drives the chip-select, address-valid, output-enable and write-enable strobes. It also controls the bus drive enable, gathers read data, and acknowledges once the access and the following idle gap are complete.

Each of the six chip-selects has its own timing word, loaded through a simple write port. Every strobe edge is a tick offset from the start of the access. A tick is one functional clock, or two clocks when the granularity flag is set. Any strobe can be pushed back by half a clock. In a page burst, the chip-select, output-enable and cycle-length terms grow by one page time for each beat after the first. The timing word is captured when a request is accepted, so rewriting it later only affects later accesses.

Top module: `amem_strobe_seq`

## Requirements
- R1: After reset, and whenever no access runs, every chip-select, adv_n, oe_n and we_n is high, ad_oe, ack and rd_valid are low.
- R2: A request is accepted on a clock edge with req high while idle. Define clock j as the j-th clock after that edge, counting from 0, and tick t(j) = floor(j / (gran+1)). Only the selected chip-select is ever low. It is low at clock j+1 when cs_on <= t(j) < cs_end, where cs_end is the clamped off time for the request's direction plus the burst extension.
- R3: With gran=1 each tick lasts two functional clocks; with gran=0 it lasts one.
- R4: adv_n is low for adv_on <= t < clamp(adv_on, adv_off of the direction). oe_n follows oe_on and the clamped oe_off plus the burst extension, on reads only. we_n follows we_on and the clamped we_off, on writes only.
- R5: An off time that is not greater than its on time is treated as on+1, so that strobe is asserted for exactly one tick.
- R6: When a strobe's extra-delay flag is set (xd_cs, xd_adv, xd_oe, xd_we), both of its edges move half a functional clock later, onto the falling clock edge.
- R7: With req_len = n-1 and page time p, where p=0 counts as 1, the burst extension is (n-1)*p ticks. The access lasts (cycle time, with 0 counted as 1, plus the extension) ticks, and the tick counter never exceeds that length.
- R8: After the access length, the block waits gap functional clocks, then holds ack high for exactly one clock. With an access of N clocks, ack is high in clock N+gap.
- R9: For ticks below the clamped adv off time, the bus drives req_addr. After that, a write drives wr_data and a read releases the bus (ad_oe low). The bus output for clock j is presented in clock j+1.
- R10: The burst start point b is the clamped oe off time minus 1 on reads, and the clamped we off time minus 1 on writes. Beat k, for k = 0..n-1, completes in the last clock of tick b+k*p. On a read, ad_in is sampled in that clock and appears on rd_data with a one-clock rd_valid pulse in the next clock. On a write, wr_beat steps to k+1 after each beat k < n-1.
- R11: Each chip-select keeps its own timing word. Writing a chip-select's word during an access to it does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_we | input | 1 | write strobe for a timing word |
| cfg_sel | input | 3 | chip-select whose timing word is written |
| cfg_word | input | 74 | timing word, package type tcfg_t |
| req | input | 1 | access request, held until ack |
| req_wr | input | 1 | 1 write, 0 read |
| req_cs | input | 3 | chip-select index 0..5 |
| req_addr | input | 16 | address placed on the bus |
| req_len | input | 3 | beats minus one |
| wr_data | input | 16 | write data for the current beat |
| ack | output | 1 | one-clock completion pulse |
| wr_beat | output | 3 | index of the write beat being driven |
| rd_valid | output | 1 | read beat captured |
| rd_data | output | 16 | captured read word |
| ad_in | input | 16 | bus value seen from the pads |
| ad_out | output | 16 | bus value to drive |
| ad_oe | output | 1 | bus drive enable |
| csn | output | 6 | active-low chip-selects |
| adv_n | output | 1 | active-low address valid |
| oe_n | output | 1 | active-low output enable |
| we_n | output | 1 | active-low write enable |

## Verification
The assertions assume that cfg_sel stays below six when cfg_we is high, that req_cs is a valid index, and that req stays high until ack. They also assume every programmed off time fits within the cycle time, so that all burst beats complete before the access ends. The random stimulus keeps on times at 7 or less, off times at 12 or less, and cycle times between 13 and 20. It lowers req in the clock where ack is seen. Directed cases deliberately use clamped off times, a zero page time and a gap of fifteen.

// File: rtl/amem_pkg.sv
package amem_pkg;
    localparam int NCS = 6;
    localparam int TW  = 5;
    localparam int DW  = 16;
    localparam int BLW = 3;
    localparam int GW  = 4;
    localparam int CSW = $clog2(NCS);
    localparam int TCW = TW + BLW + 1;

    localparam int SI_CS  = 0;
    localparam int SI_ADV = 1;
    localparam int SI_OE  = 2;
    localparam int SI_WE  = 3;

    typedef struct packed {
        logic [TW-1:0] cs_on;
        logic [TW-1:0] cs_rd_off;
        logic [TW-1:0] cs_wr_off;
        logic [TW-1:0] adv_on;
        logic [TW-1:0] adv_rd_off;
        logic [TW-1:0] adv_wr_off;
        logic [TW-1:0] oe_on;
        logic [TW-1:0] oe_off;
        logic [TW-1:0] we_on;
        logic [TW-1:0] we_off;
        logic [TW-1:0] rd_cyc;
        logic [TW-1:0] wr_cyc;
        logic [TW-1:0] page;
        logic [GW-1:0] gap;
        logic          gran;
        logic          xd_cs;
        logic          xd_adv;
        logic          xd_oe;
        logic          xd_we;
    } tcfg_t;

    typedef struct packed {
        logic           wr;
        logic [CSW-1:0] cs;
        logic [DW-1:0]  addr;
        logic [BLW-1:0] nm1;
        tcfg_t          c;
    } acc_t;

    typedef enum logic [1:0] {S_IDLE, S_ACT, S_GAP, S_DONE} seq_st_t;

    function automatic logic [TCW-1:0] fix_off(logic [TW-1:0] on, logic [TW-1:0] off);
        if (off > on) return TCW'(off);
        return TCW'(on) + TCW'(1);
    endfunction

    function automatic logic [TCW-1:0] page_eff(tcfg_t c);
        return (c.page == '0) ? TCW'(1) : TCW'(c.page);
    endfunction

    function automatic logic [TCW-1:0] burst_ext(acc_t a);
        return TCW'(a.nm1) * page_eff(a.c);
    endfunction

    function automatic logic [TCW-1:0] acc_len(acc_t a);
        logic [TW-1:0] base;
        base = a.wr ? a.c.wr_cyc : a.c.rd_cyc;
        if (base == '0) base = TW'(1);
        return TCW'(base) + burst_ext(a);
    endfunction

    function automatic logic [TCW-1:0] beat_start(acc_t a);
        if (a.wr) return fix_off(a.c.we_on, a.c.we_off) - TCW'(1);
        return fix_off(a.c.oe_on, a.c.oe_off) - TCW'(1);
    endfunction

    function automatic logic in_win(logic [TCW-1:0] t, logic [TCW-1:0] on, logic [TCW-1:0] off);
        return (t >= on) && (t < off);
    endfunction
endpackage

// File: rtl/amem_cfg_bank.sv
module amem_cfg_bank
    import amem_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [CSW-1:0] cfg_sel,
    input  tcfg_t          cfg_word,
    input  logic [CSW-1:0] rd_sel,
    output tcfg_t          rd_word
);
    tcfg_t bank [NCS];

    for (genvar i = 0; i < NCS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[i] <= '0;
            end else if (cfg_we && cfg_sel == CSW'(i)) begin
                bank[i] <= cfg_word;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NCS; k++) begin
            if (rd_sel == CSW'(k)) rd_word = bank[k];
        end
    end

    AST_CFG_SEL_OK: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> (int'(cfg_sel) < NCS)) else $error("cfg_sel out of range"); // R11
endmodule

// File: rtl/amem_timer.sv
module amem_timer
    import amem_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           req,
    input  acc_t           req_acc,
    output logic           act,
    output logic [TCW-1:0] tick,
    output logic           cap,
    output logic [BLW-1:0] beat,
    output logic           ack,
    output acc_t           cur
);
    seq_st_t        st;
    logic           ph;
    logic           ph_last;
    logic           bdone;
    logic           last;
    logic [GW-1:0]  gcnt;
    logic [TCW-1:0] nxt_bt;
    logic [TCW-1:0] len;

    assign len     = acc_len(cur);
    assign act     = (st == S_ACT);
    assign ack     = (st == S_DONE);
    assign ph_last = (ph == cur.c.gran);
    assign last    = act && ph_last && (tick == len - TCW'(1));
    assign cap     = act && !bdone && ph_last && (tick == nxt_bt);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            ph     <= 1'b0;
            tick   <= '0;
            gcnt   <= '0;
            nxt_bt <= '0;
            bdone  <= 1'b0;
            beat   <= '0;
            cur    <= '0;
        end else begin
            case (st)
                S_IDLE: if (req) begin
                    cur    <= req_acc;
                    st     <= S_ACT;
                    ph     <= 1'b0;
                    tick   <= '0;
                    beat   <= '0;
                    bdone  <= 1'b0;
                    nxt_bt <= beat_start(req_acc);
                end
                S_ACT: begin
                    ph <= ph_last ? 1'b0 : 1'b1;
                    if (ph_last) tick <= tick + TCW'(1);
                    if (cap) begin
                        if (beat == cur.nm1) bdone <= 1'b1;
                        else                 beat  <= beat + BLW'(1);
                        nxt_bt <= nxt_bt + page_eff(cur.c);
                    end
                    if (last) begin
                        if (cur.c.gap == '0) begin
                            st <= S_DONE;
                        end else begin
                            st   <= S_GAP;
                            gcnt <= cur.c.gap - GW'(1);
                        end
                    end
                end
                S_GAP: begin
                    if (gcnt == '0) st <= S_DONE;
                    else            gcnt <= gcnt - GW'(1);
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack) else $error("ack longer than one clock"); // R8
    AST_TICK_IN_LEN: assert property (@(posedge clk) disable iff (rst)
        act |-> (tick < len)) else $error("tick past access length"); // R7
    AST_BEAT_MAX: assert property (@(posedge clk) disable iff (rst)
        act |-> (beat <= cur.nm1)) else $error("beat index past burst"); // R7
endmodule

// File: rtl/amem_strobe_gen.sv
module amem_strobe_gen
    import amem_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           act,
    input  logic [TCW-1:0] tick,
    input  logic           cap,
    input  acc_t           cur,
    input  logic [DW-1:0]  wr_data,
    input  logic [DW-1:0]  ad_in,
    output logic [3:0]     strb,
    output logic [DW-1:0]  ad_out,
    output logic           ad_oe,
    output logic           rd_valid,
    output logic [DW-1:0]  rd_data
);
    logic [3:0]     want;
    logic [3:0]     s_q;
    logic [3:0]     s_h;
    logic [3:0]     xd;
    logic [TCW-1:0] ext;
    logic [TCW-1:0] adv_end;
    logic           addr_ph;
    logic           in_len;
    logic           unused_gap;

    assign unused_gap = ^cur.c.gap;
    assign ext     = burst_ext(cur);
    assign adv_end = fix_off(cur.c.adv_on, cur.wr ? cur.c.adv_wr_off : cur.c.adv_rd_off);
    assign addr_ph = tick < adv_end;
    assign in_len  = tick < acc_len(cur);

    always_comb begin
        want = '0;
        if (act && in_len) begin
            want[SI_CS]  = in_win(tick, TCW'(cur.c.cs_on),
                           fix_off(cur.c.cs_on, cur.wr ? cur.c.cs_wr_off : cur.c.cs_rd_off) + ext);
            want[SI_ADV] = in_win(tick, TCW'(cur.c.adv_on), adv_end);
            want[SI_OE]  = !cur.wr && in_win(tick, TCW'(cur.c.oe_on),
                           fix_off(cur.c.oe_on, cur.c.oe_off) + ext);
            want[SI_WE]  = cur.wr && in_win(tick, TCW'(cur.c.we_on),
                           fix_off(cur.c.we_on, cur.c.we_off));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q      <= '0;
            ad_oe    <= 1'b0;
            ad_out   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            s_q      <= want;
            ad_oe    <= act && (addr_ph || cur.wr);
            ad_out   <= !act ? '0 : (addr_ph ? cur.addr : wr_data);
            rd_valid <= cap && !cur.wr;
            if (cap && !cur.wr) rd_data <= ad_in;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) s_h <= '0;
        else     s_h <= s_q;
    end

    assign xd   = {cur.c.xd_we, cur.c.xd_oe, cur.c.xd_adv, cur.c.xd_cs};
    assign strb = (xd & s_h) | (~xd & s_q);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !act |=> (s_q == '0 && !ad_oe)) else $error("strobe outside access"); // R1
    AST_OE_WE_APART: assert property (@(posedge clk) disable iff (rst)
        !(s_q[SI_OE] && s_q[SI_WE])) else $error("oe and we together"); // R4
    AST_RD_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (cap && cur.wr) |=> !rd_valid) else $error("read capture on write"); // R10
endmodule

// File: rtl/amem_strobe_seq.sv
module amem_strobe_seq
    import amem_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [CSW-1:0]          cfg_sel,
    input  logic [$bits(tcfg_t)-1:0] cfg_word,
    input  logic                    req,
    input  logic                    req_wr,
    input  logic [CSW-1:0]          req_cs,
    input  logic [DW-1:0]           req_addr,
    input  logic [BLW-1:0]          req_len,
    input  logic [DW-1:0]           wr_data,
    output logic                    ack,
    output logic [BLW-1:0]          wr_beat,
    output logic                    rd_valid,
    output logic [DW-1:0]           rd_data,
    input  logic [DW-1:0]           ad_in,
    output logic [DW-1:0]           ad_out,
    output logic                    ad_oe,
    output logic [NCS-1:0]          csn,
    output logic                    adv_n,
    output logic                    oe_n,
    output logic                    we_n
);
    tcfg_t          sel_cfg;
    acc_t           req_acc;
    acc_t           cur;
    logic           act;
    logic           cap;
    logic [TCW-1:0] tick;
    logic [3:0]     strb;

    amem_cfg_bank i_bank (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_word(tcfg_t'(cfg_word)), .rd_sel(req_cs), .rd_word(sel_cfg)
    );

    always_comb begin
        req_acc.wr   = req_wr;
        req_acc.cs   = req_cs;
        req_acc.addr = req_addr;
        req_acc.nm1  = req_len;
        req_acc.c    = sel_cfg;
    end

    amem_timer i_timer (
        .clk(clk), .rst(rst), .req(req), .req_acc(req_acc), .act(act),
        .tick(tick), .cap(cap), .beat(wr_beat), .ack(ack), .cur(cur)
    );

    amem_strobe_gen i_gen (
        .clk(clk), .rst(rst), .act(act), .tick(tick), .cap(cap), .cur(cur),
        .wr_data(wr_data), .ad_in(ad_in), .strb(strb), .ad_out(ad_out),
        .ad_oe(ad_oe), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    for (genvar i = 0; i < NCS; i++) begin : g_csn
        assign csn[i] = !(strb[SI_CS] && cur.cs == CSW'(i));
    end
    assign adv_n = !strb[SI_ADV];
    assign oe_n  = !strb[SI_OE];
    assign we_n  = !strb[SI_WE];

    AST_ONE_CHIP: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~csn)) else $error("several chip-selects low"); // R2
endmodule

// File: tb/test_amem_strobe_seq.sv
module test_amem_strobe_seq;
    import amem_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1;
    logic cfg_we = 0, req = 0, req_wr = 0;
    logic [CSW-1:0] cfg_sel = 0, req_cs = 0;
    tcfg_t cfg_word = '0;
    logic [DW-1:0] req_addr = 0, wr_data, ad_in = 0, ad_out, rd_data;
    logic [BLW-1:0] req_len = 0, wr_beat;
    logic ack, rd_valid, ad_oe, adv_n, oe_n, we_n;
    logic [NCS-1:0] csn;
    logic [DW-1:0] wpat = 16'h3c00;

    int errors = 0, checks = 0, bcyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) bcyc <= bcyc + 1;
    assign wr_data = wpat ^ DW'(wr_beat);

    function automatic logic [15:0] hsh(int c);
        return 16'((c * 40503) ^ 23130);
    endfunction
    always @(negedge clk) ad_in <= hsh(bcyc);

    amem_strobe_seq i_amem_strobe_seq (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_word(cfg_word),
        .req(req), .req_wr(req_wr), .req_cs(req_cs), .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .ack(ack), .wr_beat(wr_beat), .rd_valid(rd_valid), .rd_data(rd_data),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .csn(csn), .adv_n(adv_n),
        .oe_n(oe_n), .we_n(we_n)
    );

    tcfg_t sh [NCS];
    int P, N, G, bp, pe, nm1, advend, ccs, c0;
    int won [4], woff [4];
    bit wen [4], cxd [4], cwr;

    task automatic chk(bit ok, string tag, string what, int actv, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, actv, expv, $time);
        end
    endtask

    function automatic int fixoff(int on, int off);
        return (off > on) ? off : on + 1;
    endfunction

    function automatic bit ideal(int s, int j);
        int t;
        if (j < 0 || j >= N || !wen[s]) return 0;
        t = j / P;
        return (t >= won[s]) && (t < woff[s]);
    endfunction

    function automatic bit is_cap(int m);
        for (int k = 0; k <= nm1; k++) if ((bp + k*pe)*P + P - 1 == m) return 1;
        return 0;
    endfunction

    function automatic int beatc(int m);
        int n = 0;
        for (int k = 0; k < nm1; k++) if ((bp + k*pe)*P + P - 1 < m) n++;
        return n;
    endfunction

    function automatic bit pin(int s);
        case (s)
            0: return !csn[ccs];
            1: return !adv_n;
            2: return !oe_n;
            default: return !we_n;
        endcase
    endfunction

    function automatic tcfg_t rcfg();
        tcfg_t c;
        c.cs_on = TW'($urandom_range(0,7));   c.cs_rd_off = TW'($urandom_range(0,12));
        c.cs_wr_off = TW'($urandom_range(0,12)); c.adv_on = TW'($urandom_range(0,7));
        c.adv_rd_off = TW'($urandom_range(0,12)); c.adv_wr_off = TW'($urandom_range(0,12));
        c.oe_on = TW'($urandom_range(0,7));   c.oe_off = TW'($urandom_range(0,12));
        c.we_on = TW'($urandom_range(0,7));   c.we_off = TW'($urandom_range(0,12));
        c.rd_cyc = TW'($urandom_range(13,20)); c.wr_cyc = TW'($urandom_range(13,20));
        c.page = TW'($urandom_range(0,4));    c.gap = GW'($urandom_range(0,5));
        c.gran = 1'($urandom_range(0,1));     c.xd_cs = 1'($urandom_range(0,1));
        c.xd_adv = 1'($urandom_range(0,1));   c.xd_oe = 1'($urandom_range(0,1));
        c.xd_we = 1'($urandom_range(0,1));
        return c;
    endfunction

    task automatic write_cfg(int cs, tcfg_t c);
        #7; cfg_we = 1; cfg_sel = CSW'(cs); cfg_word = c;
        @(posedge clk); #7; cfg_we = 0;
        @(posedge clk);
        sh[cs] = c;
    endtask

    // One access with the expected strobe timeline computed from the requirements.
    task automatic run_access(bit wr, int cs, logic [15:0] addr, int len_m1, string tag, bit rewrite);
        tcfg_t c = sh[cs];
        tcfg_t nc = rcfg();
        int ext, cyc, base;
        cwr = wr; ccs = cs; nm1 = len_m1;
        P = c.gran ? 2 : 1;
        pe = (c.page == 0) ? 1 : int'(c.page);
        ext = nm1 * pe;
        base = wr ? int'(c.wr_cyc) : int'(c.rd_cyc);
        cyc = (base == 0) ? 1 : base;
        N = (cyc + ext) * P;
        G = int'(c.gap);
        won[0] = c.cs_on;  woff[0] = fixoff(c.cs_on, wr ? c.cs_wr_off : c.cs_rd_off) + ext; wen[0] = 1;
        won[1] = c.adv_on; woff[1] = fixoff(c.adv_on, wr ? c.adv_wr_off : c.adv_rd_off);  wen[1] = 1;
        won[2] = c.oe_on;  woff[2] = fixoff(c.oe_on, c.oe_off) + ext; wen[2] = !wr;
        won[3] = c.we_on;  woff[3] = fixoff(c.we_on, c.we_off);       wen[3] = wr;
        advend = woff[1];
        bp = (wr ? fixoff(c.we_on, c.we_off) : fixoff(c.oe_on, c.oe_off)) - 1;
        cxd[0] = c.xd_cs; cxd[1] = c.xd_adv; cxd[2] = c.xd_oe; cxd[3] = c.xd_we;
        wpat = 16'($urandom);
        #7; req = 1; req_wr = wr; req_cs = CSW'(cs); req_addr = addr; req_len = BLW'(len_m1);
        @(posedge clk);
        for (int j = 0; j <= N + G + 1; j++) begin
            #2;
            for (int s = 0; s < 4; s++) begin
                bit e = cxd[s] ? ideal(s, j-2) : ideal(s, j-1);
                chk(pin(s) == e, "R6", $sformatf("%s early strobe %0d", tag, s), pin(s), e);
            end
            #5;
            if (j == 0) c0 = bcyc;
            begin
                logic [NCS-1:0] ecs = '1;
                if (ideal(0, j-1)) ecs[cs] = 1'b0;
                chk(csn == ecs, "R2", {tag, " csn"}, csn, ecs);
            end
            chk(!adv_n == ideal(1, j-1), "R4", {tag, " adv"}, !adv_n, ideal(1, j-1));
            chk(!oe_n == ideal(2, j-1), "R4", {tag, " oe"}, !oe_n, ideal(2, j-1));
            chk(!we_n == ideal(3, j-1), "R4", {tag, " we"}, !we_n, ideal(3, j-1));
            chk(ack == (j == N + G), "R8", {tag, " ack"}, ack, (j == N + G));
            begin
                int m = j - 1;
                bit eoe = 0;
                logic [15:0] ed = addr;
                if (m >= 0 && m < N) begin
                    bit adp = (m / P) < advend;
                    eoe = adp || wr;
                    if (!adp) ed = wpat ^ 16'(beatc(m));
                end
                chk(ad_oe == eoe, "R9", {tag, " ad_oe"}, ad_oe, eoe);
                if (eoe) chk(ad_out == ed, "R9", {tag, " ad_out"}, ad_out, ed);
                chk(rd_valid == (!wr && is_cap(m)), "R10", {tag, " rd_valid"}, rd_valid, (!wr && is_cap(m)));
                if (!wr && is_cap(m))
                    chk(rd_data == hsh(c0 + m), "R10", {tag, " rd_data"}, rd_data, hsh(c0 + m));
            end
            if (ack) req = 0;
            if (rewrite && j == 3) begin cfg_we = 1; cfg_sel = CSW'(cs); cfg_word = nc; end
            if (rewrite && j == 4) begin cfg_we = 0; sh[cs] = nc; end
            @(posedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++; checks++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tcfg_t d;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #7; rst = 0;
        @(posedge clk); #7;
        chk(csn == '1 && adv_n && oe_n && we_n, "R1", "reset strobes high", {csn, adv_n, oe_n, we_n}, 9'h1ff);
        chk(!ad_oe && !ack && !rd_valid, "R1", "reset bus/ack low", {ad_oe, ack, rd_valid}, 0);
        @(posedge clk);
        for (int i = 0; i < NCS; i++) write_cfg(i, rcfg());

        // R5: off times at or below on times clamp to one tick
        d = rcfg(); d.gran = 0; d.cs_on = 4; d.cs_rd_off = 2; d.oe_on = 6; d.oe_off = 6;
        d.adv_on = 3; d.adv_rd_off = 0; d.xd_cs = 0; d.xd_oe = 0;
        write_cfg(0, d);
        run_access(0, 0, 16'h1234, 0, "R5 clamp", 0);
        // R3: same timing with doubled ticks
        d.gran = 1; write_cfg(0, d);
        run_access(0, 0, 16'h4321, 0, "R3 gran", 0);
        // R7 / R10: longest read burst
        d = rcfg(); d.page = 3; write_cfg(1, d);
        run_access(0, 1, 16'hbeef, 7, "R7 R10 burst read", 0);
        // R7 / R9: write burst with page time zero
        d = rcfg(); d.page = 0; write_cfg(2, d);
        run_access(1, 2, 16'h0f0f, 3, "R7 R9 burst write", 0);
        // R8: no gap, then the longest gap
        d = rcfg(); d.gap = 0; write_cfg(4, d);
        run_access(1, 4, 16'h5555, 1, "R8 gap0", 0);
        d.gap = 15; write_cfg(4, d);
        run_access(0, 4, 16'haaaa, 1, "R8 gap15", 0);
        // R6: all strobes half a clock late
        d = rcfg(); d.xd_cs = 1; d.xd_adv = 1; d.xd_oe = 1; d.xd_we = 1; write_cfg(5, d);
        run_access(0, 5, 16'h7777, 2, "R6 late", 0);
        run_access(1, 5, 16'h8888, 2, "R6 late", 0);
        // R11: rewrite during access keeps the latched timing
        run_access(0, 3, 16'h0303, 2, "R11 rewrite", 1);
        run_access(1, 3, 16'h3030, 1, "R11 after", 0);

        for (int n = 0; n < 40; n++) begin
            int cs = $urandom_range(0, NCS-1);
            if ($urandom_range(0, 3) == 0) write_cfg(cs, rcfg());
            run_access(1'($urandom_range(0,1)), cs, 16'($urandom), $urandom_range(0,7),
                       "R2 random", 1'($urandom_range(0,5) == 0));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule